// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the central command and status register of a DMA network controller. Software starts, stops and initializes the controller by writing ones into an 8-bit register. Start, stop and initialize requests are arbitrated inside the block, and a one-cycle request goes to an external fetch engine that loads the initialization block from memory. The receive and transmit enable flags are reported back through the same register. They are raised only once any initialization fetch has finished, and only when the matching disable input is low.

A transmit-demand bit asks the descriptor logic for an immediate poll. It is accepted only while transmit is on, and the descriptor-fetch strobe retires it. An interrupt summary bit is the OR of the already-masked interrupt sources. The interrupt output is that summary gated by a software-controlled enable bit. A hard reset (asynchronous, active-low, released synchronously) and a synchronous soft reset both put the register in the stopped state.

Register layout, bit 0 first: INIT (0), START (1), STOP (2), TX_DEMAND (3), TX_ON (4), RX_ON (5), INT_EN (6), INT_SUM (7).

Top module: `netctl_csr`

## Requirements
- R1: After hard reset (`rst_n` low, asynchronous) the readback is 0x04: only STOP is set. A hard reset asserted while the controller runs takes effect without waiting for a clock edge.
- R2: Bits 0 to 3 are write-one-to-set. A write with 0 in those bits leaves INIT, START, STOP and TX_DEMAND unchanged.
- R3: A write with bit 2 = 1 sets STOP and clears START, INIT, TX_DEMAND, TX_ON, RX_ON and INT_EN at the same clock edge. This holds even when bits 0 and 1 are also 1 in that write, and then no init request is issued. STOP and START are never 1 together.
- R4: A write with bit 0 or bit 1 = 1 (and bit 2 = 0) clears STOP at that edge.
- R5: When START is written and no initialization fetch is outstanding, RX_ON becomes NOT `rx_dis` and TX_ON becomes NOT `tx_dis` at the same edge.
- R6: When INIT is written together with START, RX_ON and TX_ON stay 0 until the edge where `init_done` is sampled high. At that edge they rise according to R5.
- R7: `tx_uflow` high at an edge clears TX_ON when `uflow_keep_tx` = 0. It leaves TX_ON unchanged when `uflow_keep_tx` = 1. An underflow takes priority over a same-cycle enable.
- R8: Writing INIT while INIT is 0 sets INIT and drives `init_req` high for exactly the one cycle after the write edge. INIT then stays 1 until STOP or a reset.
- R9: Writing bit 3 = 1 sets TX_DEMAND (and `tx_poll_req`) only while TX_ON is 1. Otherwise TX_DEMAND stays 0 and no poll request is made. `desc_fetch` high at an edge clears TX_DEMAND.
- R10: INT_SUM (bit 7) is the OR of `irq_src`, registered once. `irq` is 1 exactly when INT_SUM and INT_EN are both 1.
- R11: INT_EN (bit 6) takes bit 6 of every write that has bit 2 = 0.
- R12: `soft_rst` high at an edge gives the same register state as R1, overriding any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register readback |
| init_req | output | 1 | One-cycle request to the init-block fetch engine |
| init_done | input | 1 | Fetch engine finished the init block |
| rx_dis | input | 1 | Receive-disable configuration |
| tx_dis | input | 1 | Transmit-disable configuration |
| tx_uflow | input | 1 | Transmit underflow event |
| uflow_keep_tx | input | 1 | 1: transmit stays on after underflow |
| desc_fetch | input | 1 | Transmit descriptor fetched |
| tx_poll_req | output | 1 | Transmit demand to descriptor logic |
| irq_src | input | IRQ_W | Masked interrupt sources |
| irq | output | 1 | Interrupt output |

## Verification
A write applied before clock edge k is visible in `host_rdata` just after edge k. `init_req` is high for the single cycle that follows edge k. A change on `irq_src` reaches INT_SUM and `irq` one edge later, and `init_done`, `tx_uflow` and `desc_fetch` act at the edge where they are sampled. The bench drives every input on the falling edge and samples on the following falling edge. Each check therefore falls in the first cycle after the edge that is due to produce the result. The deferred-enable test samples several cycles before `init_done` and again right after it, so an early rise of the enable flags is caught.

// File: rtl/netctl_csr_pkg.sv
package netctl_csr_pkg;
  localparam int unsigned CSR_W  = 8;
  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_TXON = 4;
  localparam int unsigned B_RXON = 5;
  localparam int unsigned B_IEN  = 6;
  localparam int unsigned B_ISUM = 7;
endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/csr_run_ctl.sv
module csr_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic wr_init,
  input  logic wr_strt,
  input  logic init_done,
  input  logic rx_dis,
  input  logic tx_dis,
  input  logic tx_uflow,
  input  logic uflow_keep_tx,
  output logic init_q,
  output logic strt_q,
  output logic stop_q,
  output logic rxon_q,
  output logic txon_q,
  output logic busy_q,
  output logic init_req_q
);
  logic init_n, strt_n, stop_n, rxon_n, txon_n, busy_n, req_n;
  logic run_now, run_nxt, go_on;

  always_comb begin
    init_n  = init_q;
    strt_n  = strt_q;
    stop_n  = stop_q;
    rxon_n  = rxon_q;
    txon_n  = txon_q;
    busy_n  = busy_q;
    req_n   = 1'b0;
    run_now = strt_q & ~busy_q;
    run_nxt = 1'b0;
    go_on   = 1'b0;
    if (halt) begin
      stop_n = 1'b1;
      strt_n = 1'b0;
      init_n = 1'b0;
      busy_n = 1'b0;
      rxon_n = 1'b0;
      txon_n = 1'b0;
    end else begin
      if (init_done) busy_n = 1'b0;
      if (wr_init || wr_strt) stop_n = 1'b0;
      if (wr_init && !init_q) begin
        init_n = 1'b1;
        busy_n = 1'b1;
        req_n  = 1'b1;
      end
      if (wr_strt) strt_n = 1'b1;
      run_nxt = strt_n & ~busy_n;
      go_on   = run_nxt & ~run_now;
      if (go_on) begin
        rxon_n = rxon_q | ~rx_dis;
        txon_n = txon_q | ~tx_dis;
      end
      if (tx_uflow && !uflow_keep_tx) txon_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= 1'b0;
      strt_q     <= 1'b0;
      stop_q     <= 1'b1;
      rxon_q     <= 1'b0;
      txon_q     <= 1'b0;
      busy_q     <= 1'b0;
      init_req_q <= 1'b0;
    end else begin
      init_q     <= init_n;
      strt_q     <= strt_n;
      stop_q     <= stop_n;
      rxon_q     <= rxon_n;
      txon_q     <= txon_n;
      busy_q     <= busy_n;
      init_req_q <= req_n;
    end
  end
endmodule

// File: rtl/csr_tx_demand.sv
module csr_tx_demand (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic wr_tdmd,
  input  logic txon_q,
  input  logic desc_fetch,
  output logic tdmd_q
);
  logic tdmd_n;

  always_comb begin
    tdmd_n = tdmd_q;
    if (halt)                   tdmd_n = 1'b0;
    else if (wr_tdmd && txon_q) tdmd_n = 1'b1;
    else if (desc_fetch)        tdmd_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdmd_q <= 1'b0;
    else        tdmd_q <= tdmd_n;
  end
endmodule

// File: rtl/csr_irq_ctl.sv
module csr_irq_ctl #(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             wr_any,
  input  logic             wr_ien,
  input  logic [IRQ_W-1:0] irq_src,
  output logic             ien_q,
  output logic             isum_q,
  output logic             irq
);
  logic ien_n, isum_n;

  always_comb begin
    ien_n = ien_q;
    if (halt)        ien_n = 1'b0;
    else if (wr_any) ien_n = wr_ien;
    isum_n = |irq_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      isum_q <= 1'b0;
    end else begin
      ien_q  <= ien_n;
      isum_q <= isum_n;
    end
  end

  assign irq = ien_q & isum_q;
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
  import netctl_csr_pkg::*;
#(
  parameter int unsigned IRQ_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             host_we,
  input  logic [CSR_W-1:0] host_wdata,
  output logic [CSR_W-1:0] host_rdata,
  output logic             init_req,
  input  logic             init_done,
  input  logic             rx_dis,
  input  logic             tx_dis,
  input  logic             tx_uflow,
  input  logic             uflow_keep_tx,
  input  logic             desc_fetch,
  output logic             tx_poll_req,
  input  logic [IRQ_W-1:0] irq_src,
  output logic             irq
);
  logic rst_sync_n;
  logic halt, wr_init, wr_strt, wr_tdmd;
  logic init_q, strt_q, stop_q, rxon_q, txon_q, fetch_busy, tdmd_q, ien_q, isum_q;

  csr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign halt    = soft_rst | (host_we & host_wdata[B_STOP]);
  assign wr_init = host_we & host_wdata[B_INIT];
  assign wr_strt = host_we & host_wdata[B_STRT];
  assign wr_tdmd = host_we & host_wdata[B_TDMD];

  csr_run_ctl u_run (
    .clk(clk), .rst_n(rst_sync_n), .halt(halt),
    .wr_init(wr_init), .wr_strt(wr_strt), .init_done(init_done),
    .rx_dis(rx_dis), .tx_dis(tx_dis),
    .tx_uflow(tx_uflow), .uflow_keep_tx(uflow_keep_tx),
    .init_q(init_q), .strt_q(strt_q), .stop_q(stop_q),
    .rxon_q(rxon_q), .txon_q(txon_q), .busy_q(fetch_busy),
    .init_req_q(init_req)
  );

  csr_tx_demand u_tdmd (
    .clk(clk), .rst_n(rst_sync_n), .halt(halt), .wr_tdmd(wr_tdmd),
    .txon_q(txon_q), .desc_fetch(desc_fetch), .tdmd_q(tdmd_q)
  );

  csr_irq_ctl #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .halt(halt),
    .wr_any(host_we), .wr_ien(host_wdata[B_IEN]), .irq_src(irq_src),
    .ien_q(ien_q), .isum_q(isum_q), .irq(irq)
  );

  always_comb begin
    host_rdata         = '0;
    host_rdata[B_INIT] = init_q;
    host_rdata[B_STRT] = strt_q;
    host_rdata[B_STOP] = stop_q;
    host_rdata[B_TDMD] = tdmd_q;
    host_rdata[B_TXON] = txon_q;
    host_rdata[B_RXON] = rxon_q;
    host_rdata[B_IEN]  = ien_q;
    host_rdata[B_ISUM] = isum_q;
  end

  assign tx_poll_req = tdmd_q;
endmodule

// File: rtl/netctl_csr_chk.sv
module netctl_csr_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       host_we,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       init_req,
  input logic       fetch_busy,
  input logic       tx_uflow,
  input logic       uflow_keep_tx,
  input logic       tx_poll_req,
  input logic       irq
);
  // R3: stop and start are mutually exclusive
  p_stop_strt_excl_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_rdata[2] && host_rdata[1]));

  // R3: a stop write wins over start and init
  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_we && host_wdata[2]) |=> (host_rdata[2] && !host_rdata[1] && !host_rdata[0]));

  // R8: init request lasts one cycle
  p_init_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_req |=> !init_req);

  // R6: receive enable never rises while a fetch is outstanding
  p_rx_after_fetch_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(host_rdata[5]) |-> (!fetch_busy && host_rdata[1]));

  // R7: underflow with keep bit low turns transmit off
  p_uflow_drop_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_uflow && !uflow_keep_tx) |=> !host_rdata[4]);

  // R9: transmit demand is only accepted while transmit is on
  p_tdmd_needs_tx_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tx_poll_req) |-> $past(host_rdata[4]));

  // R10: interrupt output needs enable and summary
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (host_rdata[6] && host_rdata[7]));
endmodule

bind netctl_csr netctl_csr_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_we(host_we),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .init_req(init_req),
  .fetch_busy(fetch_busy), .tx_uflow(tx_uflow), .uflow_keep_tx(uflow_keep_tx),
  .tx_poll_req(tx_poll_req), .irq(irq)
);

// File: tb/test_netctl_csr.sv
`timescale 1ns/1ps
module test_netctl_csr;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, host_we, init_done, rx_dis, tx_dis;
  logic       tx_uflow, uflow_keep_tx, desc_fetch;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [3:0] irq_src;
  logic       init_req, tx_poll_req, irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         reported = 1'b0;

  always #2.5 clk = ~clk;

  netctl_csr i_netctl_csr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .init_req(init_req),
    .init_done(init_done), .rx_dis(rx_dis), .tx_dis(tx_dis),
    .tx_uflow(tx_uflow), .uflow_keep_tx(uflow_keep_tx),
    .desc_fetch(desc_fetch), .tx_poll_req(tx_poll_req),
    .irq_src(irq_src), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_wdata = d;
    @(negedge clk); host_we = 1'b0; host_wdata = 8'h00;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic do_hard_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset readback", host_rdata, 8'h04);
    chk("R1 reset outputs", {5'd0, init_req, tx_poll_req, irq}, 8'h00);
  endtask

  task automatic t_plain_start();
    wr(8'h02);
    chk("R4 R5 start sets rx/tx on", host_rdata, 8'h32);
    wr(8'h00);
    chk("R2 zero write no effect", host_rdata, 8'h32);
    wr(8'h04);
    chk("R3 stop clears run bits", host_rdata, 8'h04);
    rx_dis = 1'b1;
    wr(8'h02);
    chk("R5 start with rx disabled", host_rdata, 8'h12);
    rx_dis = 1'b0;
    wr(8'h04);
  endtask

  task automatic t_triple();
    wr(8'h02);
    wr(8'h07);
    chk("R3 stop overrides start+init", host_rdata, 8'h04);
    chk("R3 no init request", {7'd0, init_req}, 8'h00);
  endtask

  task automatic t_init_start();
    tx_dis = 1'b1;
    wr(8'h03);
    chk("R8 init request pulse", {7'd0, init_req}, 8'h01);
    chk("R6 enables held during fetch", host_rdata, 8'h03);
    @(negedge clk);
    chk("R8 init request one cycle", {7'd0, init_req}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 enables still held", host_rdata, 8'h03);
    pulse(init_done);
    chk("R6 enables after init done", host_rdata, 8'h23);
    wr(8'h01);
    chk("R8 init stays set, no new request", {init_req, host_rdata[6:0]}, 8'h23);
    tx_dis = 1'b0;
    wr(8'h04);
    chk("R3 stop clears init", host_rdata, 8'h04);
  endtask

  task automatic t_underflow();
    wr(8'h02);
    uflow_keep_tx = 1'b1;
    pulse(tx_uflow);
    chk("R7 underflow with keep=1", host_rdata, 8'h32);
    uflow_keep_tx = 1'b0;
    pulse(tx_uflow);
    chk("R7 underflow with keep=0", host_rdata, 8'h22);
  endtask

  task automatic t_tdmd();
    wr(8'h08);
    chk("R9 demand ignored while tx off", host_rdata, 8'h22);
    chk("R9 no poll while tx off", {7'd0, tx_poll_req}, 8'h00);
    wr(8'h04);
    wr(8'h02);
    wr(8'h08);
    chk("R9 demand set while tx on", host_rdata, 8'h3A);
    chk("R9 poll request", {7'd0, tx_poll_req}, 8'h01);
    pulse(desc_fetch);
    chk("R9 fetch clears demand", host_rdata, 8'h32);
  endtask

  task automatic t_irq();
    wr(8'h40);
    chk("R11 enable written", host_rdata, 8'h72);
    @(negedge clk); irq_src = 4'b0100;
    @(negedge clk);
    chk("R10 summary and irq", {host_rdata[7:6], 5'd0, irq}, 8'hC1);
    wr(8'h00);
    chk("R11 enable cleared, irq gated", {host_rdata[7:6], 5'd0, irq}, 8'h80);
    wr(8'h40);
    chk("R10 irq back", {7'd0, irq}, 8'h01);
    @(negedge clk); irq_src = 4'b0000;
    @(negedge clk);
    chk("R10 summary drops", {host_rdata[7:6], 5'd0, irq}, 8'h40);
    wr(8'h44);
    chk("R3 stop clears enable", host_rdata, 8'h04);
  endtask

  task automatic t_resets();
    wr(8'h02);
    @(negedge clk); soft_rst = 1'b1; host_we = 1'b1; host_wdata = 8'h43;
    @(negedge clk); soft_rst = 1'b0; host_we = 1'b0; host_wdata = 8'h00;
    chk("R12 soft reset overrides write", host_rdata, 8'h04);
    wr(8'h02);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async hard reset", host_rdata, 8'h04);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after hard reset release", host_rdata, 8'h04);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; host_we = 1'b0; host_wdata = 8'h00;
    init_done = 1'b0; rx_dis = 1'b0; tx_dis = 1'b0; tx_uflow = 1'b0;
    uflow_keep_tx = 1'b0; desc_fetch = 1'b0; irq_src = 4'b0000;
    @(negedge clk);
    do_hard_reset();
    t_reset();
    t_plain_start();
    t_triple();
    t_init_start();
    t_underflow();
    t_tdmd();
    t_irq();
    t_resets();
    report();
    $finish;
  end
endmodule